// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block carries one two-word message (a command word and a pointer word) from a sending processor to a receiving processor. It has two small register ports, one per processor, each with a write strobe, a 2-bit register index, write data and combinational read data. The sender first stages the pointer word and then writes the command word. That command write commits the message and marks the slot occupied. The receiver reads the pointer word and then the command word. Its command read frees the slot.

Each side has its own interrupt line and its own mask register. The receiver can be interrupted while a message waits. The sender can be interrupted while the slot is free. Only the sender keeps what it writes to its pointer register, so software can tell the two ports apart by writing a pattern and reading it back.

Top module: `msg_mailbox`

## Requirements
- R1: After reset every register on both ports reads 0, and both interrupt lines are low.
- R2: The sender pointer register (index 1) reads back the last value written to it, for example 0xA5A5AA55, whether or not a message is waiting.
- R3: On the receiver port, a write to index 1 has no effect. Index 1 on this port reads the pointer word of the last committed message.
- R4: When the slot is empty, a sender write to index 0 commits the message. From the next cycle the stored command is the written data and the stored pointer is the staged sender pointer, and status (index 2) reads 3 on both ports. Bit 0 is pending and bit 1 is full.
- R5: When the slot is full, a sender write to index 0 is ignored. The stored command word, the stored pointer word and the status stay unchanged.
- R6: When the slot is full, a receiver read of index 0 returns the stored command and clears both status bits at that clock edge. Other receiver reads, and receiver reads of index 0 while the slot is empty, change nothing.
- R7: The receiver interrupt is a register that takes (full AND receiver mask bit 0) at each clock edge.
- R8: The sender interrupt is a register that takes (NOT full AND sender mask bit 1) at each clock edge.
- R9: Each port's mask register (index 3) reads back the full 32-bit value last written on that same port. The two mask registers are independent.
- R10: Writes to status on either port, and receiver writes to index 0, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sWrEn | input | 1 | Sender write strobe |
| sSel | input | 2 | Sender register index (byte offset / 4) |
| sWrData | input | DATA_W | Sender write data |
| sRdData | output | DATA_W | Sender read data, combinational |
| rWrEn | input | 1 | Receiver write strobe |
| rRdEn | input | 1 | Receiver read strobe (a read of index 0 frees the slot) |
| rSel | input | 2 | Receiver register index |
| rWrData | input | DATA_W | Receiver write data |
| rRdData | output | DATA_W | Receiver read data, combinational |
| sIrq | output | 1 | Sender space-available interrupt |
| rIrq | output | 1 | Receiver message-pending interrupt |

## Verification
A wrong occupancy flag shows up at once in the status word on both ports. It also shows one cycle later on the interrupt lines, so the bench compares every output on every clock against a behavioural model. If a commit or a take is lost or doubled, the flag either sticks or drops early, and the next status read exposes it. If a message word is overwritten by an ignored post or by a stray pointer write, the receiver's next pointer or command read shows the wrong value.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [1:0] REG_CMD = 2'd0;
  localparam logic [1:0] REG_PTR = 2'd1;
  localparam logic [1:0] REG_STS = 2'd2;
  localparam logic [1:0] REG_MSK = 2'd3;

  typedef struct packed {
    logic stageWr;
    logic commit;
    logic take;
    logic sMaskWr;
    logic rMaskWr;
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sWrEn,
  input  logic [1:0]   sSel,
  input  logic         rWrEn,
  input  logic         rRdEn,
  input  logic [1:0]   rSel,
  input  logic         sSpaceEn,
  input  logic         rPendEn,
  output mbox_strobe_t strobe,
  output logic         busy,
  output logic         sIrq,
  output logic         rIrq
);
  logic postReq, takeReq;

  assign postReq = sWrEn && (sSel == REG_CMD);
  assign takeReq = rRdEn && (rSel == REG_CMD);

  always_comb begin
    strobe.stageWr = sWrEn && (sSel == REG_PTR);
    strobe.commit  = postReq && !busy;
    strobe.take    = takeReq && busy;
    strobe.sMaskWr = sWrEn && (sSel == REG_MSK);
    strobe.rMaskWr = rWrEn && (rSel == REG_MSK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sIrq <= 1'b0;
      rIrq <= 1'b0;
    end else begin
      if (strobe.take)        busy <= 1'b0;
      else if (strobe.commit) busy <= 1'b1;
      sIrq <= !busy && sSpaceEn;
      rIrq <= busy && rPendEn;
    end
  end

  // R4
  post_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (postReq && !busy) |=> busy);
  // R6
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (takeReq && busy) |=> !busy);
  // R6
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !takeReq) |=> busy);
  // R7
  rx_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rIrq == $past(busy && rPendEn)));
  // R8
  tx_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sIrq == $past(!busy && sSpaceEn)));
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mbox_strobe_t      strobe,
  input  logic              busy,
  input  logic [1:0]        sSel,
  input  logic [1:0]        rSel,
  input  logic [DATA_W-1:0] sWrData,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] sRdData,
  output logic [DATA_W-1:0] rRdData,
  output logic              sSpaceEn,
  output logic              rPendEn
);
  localparam int PAD_W = DATA_W - 2;

  logic [DATA_W-1:0] stagePtr, msgCmd, msgPtr, sMask, rMask;
  logic [DATA_W-1:0] statusWord;

  assign statusWord = {{PAD_W{1'b0}}, busy, busy};
  assign sSpaceEn   = sMask[1];
  assign rPendEn    = rMask[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stagePtr <= '0;
      msgCmd   <= '0;
      msgPtr   <= '0;
      sMask    <= '0;
      rMask    <= '0;
    end else begin
      if (strobe.stageWr) stagePtr <= sWrData;
      if (strobe.commit) begin
        msgCmd <= sWrData;
        msgPtr <= stagePtr;
      end
      if (strobe.sMaskWr) sMask <= sWrData;
      if (strobe.rMaskWr) rMask <= rWrData;
    end
  end

  always_comb begin
    unique case (sSel)
      REG_CMD: sRdData = msgCmd;
      REG_PTR: sRdData = stagePtr;
      REG_STS: sRdData = statusWord;
      default: sRdData = sMask;
    endcase
    unique case (rSel)
      REG_CMD: rRdData = msgCmd;
      REG_PTR: rRdData = msgPtr;
      REG_STS: rRdData = statusWord;
      default: rRdData = rMask;
    endcase
  end

  // R5
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> ($stable(msgCmd) && $stable(msgPtr)));
  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.rMaskWr |=> $stable(rMask));
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sWrEn,
  input  logic [1:0]        sSel,
  input  logic [DATA_W-1:0] sWrData,
  output logic [DATA_W-1:0] sRdData,
  input  logic              rWrEn,
  input  logic              rRdEn,
  input  logic [1:0]        rSel,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              sIrq,
  output logic              rIrq
);
  mbox_strobe_t strobe;
  logic busy, sSpaceEn, rPendEn;

  mbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sWrEn(sWrEn), .sSel(sSel),
    .rWrEn(rWrEn), .rRdEn(rRdEn), .rSel(rSel),
    .sSpaceEn(sSpaceEn), .rPendEn(rPendEn),
    .strobe(strobe), .busy(busy), .sIrq(sIrq), .rIrq(rIrq)
  );

  mbox_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .busy(busy),
    .sSel(sSel), .rSel(rSel), .sWrData(sWrData), .rWrData(rWrData),
    .sRdData(sRdData), .rRdData(rRdData),
    .sSpaceEn(sSpaceEn), .rPendEn(rPendEn)
  );
endmodule

// File: tb/msg_mailbox_test.sv
module msg_mailbox_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sWrEn = 1'b0, rWrEn = 1'b0, rRdEn = 1'b0;
  logic [1:0] sSel = 2'd0, rSel = 2'd0;
  logic [31:0] sWrData = '0, rWrData = '0;
  logic [31:0] sRdData, rRdData;
  logic sIrq, rIrq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [31:0] mStage = '0, mCmd = '0, mPtr = '0, mSMask = '0, mRMask = '0;
  logic mBusy = 1'b0, eSIrq = 1'b0, eRIrq = 1'b0;

  always #4 clk = ~clk;

  msg_mailbox uut (
    .clk(clk), .rst_n(rst_n), .sWrEn(sWrEn), .sSel(sSel), .sWrData(sWrData),
    .sRdData(sRdData), .rWrEn(rWrEn), .rRdEn(rRdEn), .rSel(rSel),
    .rWrData(rWrData), .rRdData(rRdData), .sIrq(sIrq), .rIrq(rIrq)
  );

  function automatic logic [31:0] sExp(input logic [1:0] a);
    case (a)
      2'd0: return mCmd;
      2'd1: return mStage;
      2'd2: return {30'd0, mBusy, mBusy};
      default: return mSMask;
    endcase
  endfunction

  function automatic logic [31:0] rExp(input logic [1:0] a);
    case (a)
      2'd0: return mCmd;
      2'd1: return mPtr;
      2'd2: return {30'd0, mBusy, mBusy};
      default: return mRMask;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic sWe, input logic [1:0] sA, input logic [31:0] sD,
                      input logic rWe, input logic rRe, input logic [1:0] rA,
                      input logic [31:0] rD, input string tag);
    logic take, post;
    @(negedge clk);
    sWrEn = sWe; sSel = sA; sWrData = sD;
    rWrEn = rWe; rRdEn = rRe; rSel = rA; rWrData = rD;
    #1;
    check({tag, " sender read"}, sRdData, sExp(sA));
    check({tag, " receiver read"}, rRdData, rExp(rA));
    check("R7 rIrq", {31'd0, rIrq}, {31'd0, eRIrq});
    check("R8 sIrq", {31'd0, sIrq}, {31'd0, eSIrq});
    @(posedge clk);
    eRIrq = mBusy && mRMask[0];
    eSIrq = !mBusy && mSMask[1];
    take = rRe && (rA == 2'd0) && mBusy;
    post = sWe && (sA == 2'd0) && !mBusy;
    if (post) begin mCmd = sD; mPtr = mStage; end
    if (sWe && sA == 2'd1) mStage = sD;
    if (sWe && sA == 2'd3) mSMask = sD;
    if (rWe && rA == 2'd3) mRMask = rD;
    if (take) mBusy = 1'b0;
    else if (post) mBusy = 1'b1;
  endtask

  task automatic sWr(input logic [1:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 1'b0, a, 32'd0, tag);
  endtask
  task automatic rWr(input logic [1:0] a, input logic [31:0] d, input string tag);
    step(1'b0, a, 32'd0, 1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rRd(input logic [1:0] a, input string tag);
    step(1'b0, a, 32'd0, 1'b0, 1'b1, a, 32'd0, tag);
  endtask
  task automatic look(input logic [1:0] a, input string tag);
    step(1'b0, a, 32'd0, 1'b0, 1'b0, a, 32'd0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 4; a++) look(a[1:0], "R1");
    // R2 sender pointer pattern readback
    sWr(2'd1, 32'hA5A5AA55, "R2");
    look(2'd1, "R2");
    // R3 receiver pointer does not hold writes
    rWr(2'd1, 32'h12345678, "R3");
    look(2'd1, "R3");
    // R9 masks per port
    sWr(2'd3, 32'h0000_F002, "R9");
    rWr(2'd3, 32'h0000_0C01, "R9");
    look(2'd3, "R9");
    look(2'd3, "R8 space irq");
    // R4 post a message
    sWr(2'd1, 32'h0000_1000, "R4");
    sWr(2'd0, 32'hC0DE_0001, "R4");
    look(2'd2, "R4 status");
    look(2'd2, "R7 pending irq");
    // R5 ignored post while full; R2 staging still works
    sWr(2'd1, 32'h0000_2000, "R2");
    sWr(2'd0, 32'h0000_0BAD, "R5");
    look(2'd0, "R5 cmd kept");
    rRd(2'd1, "R5 ptr kept");
    // R6 pointer read has no side effect
    rRd(2'd1, "R6");
    look(2'd2, "R6 still full");
    rRd(2'd0, "R6 take");
    look(2'd2, "R6 cleared");
    rRd(2'd0, "R6 empty read");
    look(2'd2, "R6");
    // R10 ignored writes
    rWr(2'd0, 32'hFFFF_FFFF, "R10");
    rWr(2'd2, 32'hFFFF_FFFF, "R10");
    sWr(2'd2, 32'hFFFF_FFFF, "R10");
    look(2'd2, "R10");
    look(2'd0, "R10");
    // second message uses staged pointer
    sWr(2'd0, 32'h0000_0077, "R4");
    rRd(2'd1, "R4");
    rWr(2'd3, 32'd0, "R7 mask off");
    look(2'd2, "R7");
    look(2'd2, "R7");
    rWr(2'd3, 32'd1, "R7 mask on");
    look(2'd2, "R7");
    look(2'd2, "R7");
    sWr(2'd3, 32'd0, "R8 mask off");
    rRd(2'd0, "R6 take");
    look(2'd2, "R8");
    look(2'd2, "R8");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule